// File: doc/BRIEF.md
# Data-Strobe Link Character Receiver

This block takes a serial link made of two wires, a data wire and a strobe wire. Exactly one of the two toggles for every bit. Both wires pass through a two-flop synchroniser. A bit is taken whenever the exclusive-OR of the two synchronised wires changes, and the bit's value is the data wire. The bits are framed into link characters and decoded. The block reports, one clock at a time, the tokens and characters it finds: flow-control tokens, NULLs, data bytes, packet markers and time codes. It also reports framing faults: bad parity, an illegal escape sequence, and a silent line (disconnection).

The receiver starts in a hunting mode. It stays there, reporting nothing except that bits are arriving, until the bit pattern of a NULL (escape followed by flow-control) goes past. From that point on, characters are framed back to back. Any fault is reported once, after which the decoder stays silent until `rx_en` is taken low and raised again.

The character and time-code outputs are valid-only streams with no ready. The wire cannot be stalled, so back-pressure is not possible: a consumer must accept every `char_valid` or `time_valid` pulse in the cycle it is shown. The data fields are meaningful only while their valid is high.

Top module: `ds_link_rx`

## Requirements
- R1: Each change of (data XOR strobe) after synchronisation is one bit whose value is the data wire; `got_bit` rises after the first bit and is cleared while `rx_en` is low.
- R2: Until the seven bits 1,1,1,0,1,0,0 (in arrival order, after any parity bit) have been seen, no event or error output pulses. When they are seen, `null_seen` pulses once and framing starts with the next bit.
- R3: Every character is a parity bit, then a flag bit, then its payload. Flag 0 means 8 data bits sent least significant first, reported as `char_valid` with `char_flag`=0 and the byte on `char_data`.
- R4: Flag 1 means 2 control bits (first, second): 0,0 is a flow-control token (`fct_seen`); 0,1 is end-of-packet (`char_valid`, `char_flag`=1, `char_data`=0x00); 1,0 is error-end-of-packet (`char_flag`=1, `char_data`=0x01); 1,1 is escape.
- R5: Escape then flow-control gives one `null_seen` pulse. Escape then a data character gives `time_valid`, with `time_value` equal to byte bits 5:0 and `time_ctrl` equal to byte bits 7:6.
- R6: Escape followed by escape, end-of-packet or error-end-of-packet pulses `err_escape`.
- R7: For each character, (XOR of the previous character's payload bits) XOR parity XOR flag must be 1, otherwise `err_parity` pulses; the NULL that ends hunting counts as a previous payload of 0,0.
- R8: After framing has started, if no bit arrives for `DISC_CYCLES` clocks then `err_disconnect` pulses, between `DISC_CYCLES` and `DISC_CYCLES`+4 clocks after the last wire change.
- R9: Each error pulse lasts one clock; afterwards no output pulses until `rx_en` goes low and high again, which restarts hunting.
- R10: At most one of the event and error outputs is high in any cycle.
- R11: During reset, and in the clock after `rx_en` is low, `got_bit` and all pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low clears and restarts hunting |
| ds_d | input | 1 | Data wire, asynchronous |
| ds_s | input | 1 | Strobe wire, asynchronous |
| got_bit | output | 1 | At least one bit seen since enable |
| null_seen | output | 1 | NULL decoded (pulse) |
| fct_seen | output | 1 | Flow-control token decoded (pulse) |
| char_valid | output | 1 | Data byte or packet marker valid (pulse) |
| char_flag | output | 1 | 1 = packet marker, 0 = data byte |
| char_data | output | 8 | Byte, or 0x00/0x01 for markers |
| time_valid | output | 1 | Time code valid (pulse) |
| time_ctrl | output | 2 | Time code control bits |
| time_value | output | 6 | Time code count |
| err_parity | output | 1 | Parity fault (pulse) |
| err_escape | output | 1 | Illegal escape sequence (pulse) |
| err_disconnect | output | 1 | Line silent too long (pulse) |

## Verification
The hardest state to reach is a fault deep inside a framed stream. Parity is chained from one character to the next, so a bad parity or escape pairing only means something after hunting has ended and every earlier character has been framed correctly. The stimulus uses an encoder in the bench that keeps the running payload parity for every character it sends. Random streams of bytes, tokens, markers and time codes are sent first. After that, a deliberately wrong parity bit or an illegal escape pairing is injected. Further characters are then sent to show that the decoder stays silent. Disconnection is reached by stopping the encoder after a bit. The clocks until the fault are counted against a gap that was just short of the limit.

// File: rtl/ds_rx_pkg.sv
package ds_rx_pkg;
  typedef enum logic [1:0] {DEC_HUNT, DEC_RUN, DEC_HALT} dec_state_e;

  // control codes: {first bit, second bit} after the flag bit
  localparam logic [1:0] CC_FCT = 2'b00;
  localparam logic [1:0] CC_EOP = 2'b01;
  localparam logic [1:0] CC_EEP = 2'b10;
  localparam logic [1:0] CC_ESC = 2'b11;

  // last seven bits of a NULL, oldest in bit 6
  localparam logic [6:0] NULL_TAIL = 7'b1110100;

  typedef struct packed {
    logic nul;
    logic fct;
    logic chr;
    logic tcode;
    logic perr;
    logic eerr;
    logic derr;
  } rx_evt_t;
endpackage

// File: rtl/ds_rx_sync.sv
module ds_rx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg <= '0;
        else        stg <= din;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], din};
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/ds_rx_bitdet.sv
module ds_rx_bitdet (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d,
  input  logic s,
  output logic bit_stb,
  output logic bit_val
);
  logic x_now, x_prev;

  assign x_now = d ^ s;

  // previous level tracks even while disabled so enabling adds no bit
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) x_prev <= 1'b0;
    else        x_prev <= x_now;

  assign bit_stb = en & (x_now ^ x_prev);
  assign bit_val = d;
endmodule

// File: rtl/ds_rx_disc.sv
module ds_rx_disc #(
  parameter int LIMIT = 212
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic bit_stb,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  cnt <= '0;
    else if (!arm || bit_stb)    cnt <= '0;
    else if (cnt != TOP)         cnt <= cnt + 1'b1;

  assign expire = arm & ~bit_stb & (cnt == TOP);
endmodule

// File: rtl/ds_rx_decode.sv
module ds_rx_decode
  import ds_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       bit_stb,
  input  logic       bit_val,
  input  logic       expire,
  output logic       locked,
  output logic       halted,
  output rx_evt_t    evt,
  output logic       flag_o,
  output logic [7:0] byte_o
);
  dec_state_e st;
  logic [6:0] win;
  logic [3:0] cnt;
  logic       par_q, flag_q, prev_par, esc;
  logic [7:0] sh;

  logic [6:0] win_nx;
  logic [7:0] sh_nx;
  logic [1:0] code;
  logic       last, pay_par, par_ok;

  always_comb begin
    win_nx  = {win[5:0], bit_val};
    sh_nx   = {bit_val, sh[7:1]};
    code    = {sh_nx[6], sh_nx[7]};
    last    = flag_q ? (cnt == 4'd3) : (cnt == 4'd9);
    pay_par = flag_q ? (sh_nx[6] ^ sh_nx[7]) : (^sh_nx);
    par_ok  = prev_par ^ par_q ^ flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= DEC_HUNT; win <= '0; cnt <= '0; par_q <= 1'b0; flag_q <= 1'b0;
      prev_par <= 1'b0; esc <= 1'b0; sh <= '0; evt <= '0;
      flag_o <= 1'b0; byte_o <= '0;
    end else begin
      evt <= '0;
      if (!en) begin
        st <= DEC_HUNT; win <= '0; cnt <= '0; esc <= 1'b0; prev_par <= 1'b0;
      end else begin
        case (st)
          DEC_HUNT: if (bit_stb) begin
            win <= win_nx;
            if (win_nx == NULL_TAIL) begin
              st <= DEC_RUN; evt.nul <= 1'b1;
              cnt <= '0; esc <= 1'b0; prev_par <= 1'b0;
            end
          end
          DEC_RUN: if (expire) begin
            evt.derr <= 1'b1; st <= DEC_HALT;
          end else if (bit_stb) begin
            if (cnt == 4'd0) begin
              par_q <= bit_val; cnt <= 4'd1;
            end else if (cnt == 4'd1) begin
              flag_q <= bit_val; cnt <= 4'd2;
            end else begin
              sh <= sh_nx;
              if (!last) cnt <= cnt + 4'd1;
              else begin
                cnt <= '0; prev_par <= pay_par;
                if (!par_ok) begin
                  evt.perr <= 1'b1; st <= DEC_HALT;
                end else if (flag_q) begin
                  case (code)
                    CC_FCT: if (esc) begin evt.nul <= 1'b1; esc <= 1'b0; end
                            else evt.fct <= 1'b1;
                    CC_ESC: if (esc) begin evt.eerr <= 1'b1; st <= DEC_HALT; end
                            else esc <= 1'b1;
                    default: if (esc) begin evt.eerr <= 1'b1; st <= DEC_HALT; end
                             else begin
                               evt.chr <= 1'b1; flag_o <= 1'b1;
                               byte_o <= {7'd0, code == CC_EEP};
                             end
                  endcase
                end else if (esc) begin
                  evt.tcode <= 1'b1; byte_o <= sh_nx; esc <= 1'b0;
                end else begin
                  evt.chr <= 1'b1; flag_o <= 1'b0; byte_o <= sh_nx;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign locked = (st == DEC_RUN);
  assign halted = (st == DEC_HALT);
endmodule

// File: rtl/ds_link_rx.sv
module ds_link_rx
  import ds_rx_pkg::*;
#(
  parameter int DISC_CYCLES = 212,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       ds_d,
  input  logic       ds_s,
  output logic       got_bit,
  output logic       null_seen,
  output logic       fct_seen,
  output logic       char_valid,
  output logic       char_flag,
  output logic [7:0] char_data,
  output logic       time_valid,
  output logic [1:0] time_ctrl,
  output logic [5:0] time_value,
  output logic       err_parity,
  output logic       err_escape,
  output logic       err_disconnect
);
  logic [1:0] wires_sync;
  logic       bit_stb, bit_val, expire, dec_locked, dec_halted;
  rx_evt_t    evt;
  logic [7:0] dec_byte;

  ds_rx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({ds_d, ds_s}), .dout(wires_sync));

  ds_rx_bitdet u_bitdet (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .d(wires_sync[1]), .s(wires_sync[0]),
    .bit_stb(bit_stb), .bit_val(bit_val));

  ds_rx_disc #(.LIMIT(DISC_CYCLES)) u_disc (
    .clk(clk), .rst_n(rst_n), .arm(dec_locked), .bit_stb(bit_stb), .expire(expire));

  ds_rx_decode u_dec (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .bit_stb(bit_stb), .bit_val(bit_val),
    .expire(expire), .locked(dec_locked), .halted(dec_halted), .evt(evt),
    .flag_o(char_flag), .byte_o(dec_byte));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      got_bit <= 1'b0;
    else if (!rx_en) got_bit <= 1'b0;
    else if (bit_stb) got_bit <= 1'b1;

  assign null_seen      = evt.nul;
  assign fct_seen       = evt.fct;
  assign char_valid     = evt.chr;
  assign time_valid     = evt.tcode;
  assign err_parity     = evt.perr;
  assign err_escape     = evt.eerr;
  assign err_disconnect = evt.derr;
  assign char_data      = dec_byte;
  assign time_value     = dec_byte[5:0];
  assign time_ctrl      = dec_byte[7:6];
endmodule

// File: rtl/ds_link_rx_chk.sv
module ds_link_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       got_bit,
  input logic       null_seen,
  input logic       fct_seen,
  input logic       char_valid,
  input logic       char_flag,
  input logic [7:0] char_data,
  input logic       time_valid,
  input logic       err_parity,
  input logic       err_escape,
  input logic       err_disconnect,
  input logic       locked,
  input logic       halted
);
  logic [6:0] pulses;
  logic       any_err;
  assign pulses  = {null_seen, fct_seen, char_valid, time_valid,
                    err_parity, err_escape, err_disconnect};
  assign any_err = err_parity | err_escape | err_disconnect;

  p_one_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulses));

  p_quiet_hunt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !halted) |-> (pulses == 7'd0));

  p_err_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    any_err |-> halted);

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted)) |-> (pulses == 7'd0));

  p_gotbit_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (got_bit && rx_en) |=> got_bit);

  p_disable_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!got_bit && pulses == 7'd0));

  p_marker_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && char_flag) |-> (char_data[7:1] == 7'd0));

  p_disc_after_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_disconnect |-> got_bit);
endmodule

bind ds_link_rx ds_link_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .got_bit(got_bit),
  .null_seen(null_seen), .fct_seen(fct_seen), .char_valid(char_valid),
  .char_flag(char_flag), .char_data(char_data), .time_valid(time_valid),
  .err_parity(err_parity), .err_escape(err_escape), .err_disconnect(err_disconnect),
  .locked(dec_locked), .halted(dec_halted));

// File: tb/ds_link_rx_tb.sv
module ds_link_rx_tb;
  localparam int DISC = 212;
  localparam logic [1:0] FCT = 2'b00, EOP = 2'b01, EEP = 2'b10, ESC = 2'b11;
  localparam logic [3:0] K_NUL = 4'd1, K_FCT = 4'd2, K_CHR = 4'd3, K_TIM = 4'd4,
                         K_PAR = 4'd5, K_ESC = 4'd6, K_DIS = 4'd7;

  logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0, ds_d = 1'b0, ds_s = 1'b0;
  logic got_bit, null_seen, fct_seen, char_valid, char_flag, time_valid;
  logic err_parity, err_escape, err_disconnect;
  logic [7:0] char_data;
  logic [1:0] time_ctrl;
  logic [5:0] time_value;

  always #2 clk = ~clk;

  ds_link_rx #(.DISC_CYCLES(DISC)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ds_d(ds_d), .ds_s(ds_s),
    .got_bit(got_bit), .null_seen(null_seen), .fct_seen(fct_seen),
    .char_valid(char_valid), .char_flag(char_flag), .char_data(char_data),
    .time_valid(time_valid), .time_ctrl(time_ctrl), .time_value(time_value),
    .err_parity(err_parity), .err_escape(err_escape), .err_disconnect(err_disconnect));

  int n_chk = 0, n_fail = 0, cyc = 0, gap_fix = 0, last_edge = 0, disc_cyc = 0;
  bit done = 0, tx_par = 0, m_esc = 0, m_halt = 0, m_lock = 0;
  logic [12:0] got_q[$], exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      chk(0, "watchdog", cyc, 150000);
      summary();
    end
  end

  // event monitor, away from the active edge
  always @(negedge clk) if (rst_n) begin
    int n;
    n = $countones({null_seen, fct_seen, char_valid, time_valid,
                    err_parity, err_escape, err_disconnect});
    if (n > 1) chk(0, "R10 single event per cycle", n, 1);
    if (null_seen)  got_q.push_back({K_NUL, 9'd0});
    if (fct_seen)   got_q.push_back({K_FCT, 9'd0});
    if (char_valid) got_q.push_back({K_CHR, char_flag, char_data});
    if (time_valid) got_q.push_back({K_TIM, 1'b0, time_ctrl, time_value});
    if (err_parity) got_q.push_back({K_PAR, 9'd0});
    if (err_escape) got_q.push_back({K_ESC, 9'd0});
    if (err_disconnect) begin got_q.push_back({K_DIS, 9'd0}); disc_cyc = cyc; end
  end

  task automatic send_bit(input logic b);
    int gap;
    @(negedge clk);
    ds_s = ~(ds_s ^ ds_d ^ b);
    ds_d = b;
    last_edge = cyc;
    gap = (gap_fix > 0) ? gap_fix : 3 + int'($urandom % 4);
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic send_ctrl(input logic [1:0] cc, input bit bad);
    send_bit(tx_par ^ bad); send_bit(1'b1); send_bit(cc[1]); send_bit(cc[0]);
    tx_par = cc[1] ^ cc[0];
  endtask

  task automatic send_data(input logic [7:0] v, input bit bad);
    send_bit(~tx_par ^ bad); send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
    tx_par = ^v;
  endtask

  // reference model of the decoded stream
  task automatic mdl_ctrl(input logic [1:0] cc);
    if (!m_lock || m_halt) return;
    if (m_esc) begin
      if (cc == FCT) begin exp_q.push_back({K_NUL, 9'd0}); m_esc = 0; end
      else begin exp_q.push_back({K_ESC, 9'd0}); m_halt = 1; end
    end else case (cc)
      FCT: exp_q.push_back({K_FCT, 9'd0});
      EOP: exp_q.push_back({K_CHR, 1'b1, 8'h00});
      EEP: exp_q.push_back({K_CHR, 1'b1, 8'h01});
      default: m_esc = 1;
    endcase
  endtask

  task automatic mdl_data(input logic [7:0] v);
    if (!m_lock || m_halt) return;
    if (m_esc) begin exp_q.push_back({K_TIM, 1'b0, v}); m_esc = 0; end
    else exp_q.push_back({K_CHR, 1'b0, v});
  endtask

  task automatic mdl_err(input logic [3:0] k);
    if (!m_lock || m_halt) return;
    exp_q.push_back({k, 9'd0}); m_halt = 1;
  endtask

  task automatic tx_ctrl(input logic [1:0] cc); send_ctrl(cc, 0); mdl_ctrl(cc); endtask
  task automatic tx_data(input logic [7:0] v);  send_data(v, 0);  mdl_data(v);  endtask

  task automatic lock_null();
    tx_par = 0;
    send_ctrl(ESC, 0); send_ctrl(FCT, 0);
    exp_q.push_back({K_NUL, 9'd0});
    m_lock = 1; m_esc = 0; m_halt = 0;
  endtask

  // noise with no run of three ones: bit pairs 0,1 and flow-control tokens
  task automatic junk(input int n);
    for (int i = 0; i < n; i++) begin
      if ($urandom % 2) begin send_bit(1'b0); send_bit(1'b1); end
      else begin send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); end
    end
  endtask

  task automatic compare(input string req);
    int n;
    repeat (10) @(negedge clk);
    chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    for (int i = 0; i < n; i++) chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    got_q.delete(); exp_q.delete();
  endtask

  task automatic restart();
    @(negedge clk); rx_en = 0;
    repeat (3) @(negedge clk);
    chk(got_bit == 0, "R11 disabled clears got_bit", got_bit, 0);
    rx_en = 1; m_lock = 0; m_esc = 0; m_halt = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'h1d5c0de));
    repeat (4) @(negedge clk);
    chk({got_bit, null_seen, fct_seen, char_valid, time_valid, err_parity,
         err_escape, err_disconnect} == 8'd0, "R11 reset outputs", 0, 0);
    rst_n = 1; rx_en = 1;
    repeat (3) @(negedge clk);
    chk(got_bit == 0, "R1 no bit yet", got_bit, 0);

    // hunting: noise and tokens produce nothing but got_bit
    junk(8);
    chk(got_bit == 1, "R1 got_bit after first bits", got_bit, 1);
    compare("R2 silent while hunting");
    lock_null();
    compare("R2 first NULL ends hunting");

    // directed corners then a random stream (R3 R4 R5 R7 good parity)
    tx_data(8'h00); tx_data(8'hFF); tx_data(8'h01); tx_data(8'h80);
    tx_ctrl(ESC); tx_data(8'hFF);
    tx_ctrl(ESC); tx_data(8'h00);
    tx_ctrl(EOP); tx_ctrl(EEP); tx_ctrl(FCT);
    tx_ctrl(ESC); tx_ctrl(FCT);
    for (int i = 0; i < 300; i++) begin
      v = 8'($urandom);
      case ($urandom % 6)
        0, 1: tx_data(v);
        2: tx_ctrl(FCT);
        3: tx_ctrl(($urandom % 2) ? EOP : EEP);
        4: begin tx_ctrl(ESC); tx_ctrl(FCT); end
        default: begin tx_ctrl(ESC); tx_data(v); end
      endcase
    end
    compare("R3 R4 R5 R7 random stream");

    // R6: escape then end-of-packet, then R9 silence while halted
    tx_ctrl(ESC); tx_ctrl(EOP);
    tx_data(8'h5A); tx_ctrl(FCT); tx_ctrl(ESC); tx_ctrl(FCT);
    compare("R6 R9 escape+EOP then halted");
    chk(got_bit == 1, "R9 got_bit kept while halted", got_bit, 1);

    restart();
    lock_null(); tx_data(8'hC3); tx_ctrl(ESC); tx_ctrl(ESC); tx_data(8'h11);
    compare("R6 R9 escape+escape after re-enable");

    restart();
    lock_null(); tx_ctrl(ESC); tx_ctrl(EEP);
    compare("R6 escape+EEP");

    // R7: wrong parity on a data character
    restart();
    lock_null(); tx_data(8'h96);
    send_data(8'h3C, 1); mdl_err(K_PAR);
    tx_data(8'h22);
    compare("R7 bad parity on data");

    // R7: wrong parity on a control character
    restart();
    lock_null(); tx_ctrl(FCT); tx_data(8'h07);
    send_ctrl(EOP, 1); mdl_err(K_PAR);
    compare("R7 bad parity on control");

    // R8: a long gap below the limit is fine, then silence trips it
    restart();
    lock_null();
    gap_fix = DISC - 20; tx_data(8'hA5); gap_fix = 0;
    tx_data(8'h3E);
    repeat (DISC + 20) @(negedge clk);
    mdl_err(K_DIS);
    compare("R8 disconnect after silence");
    chk(disc_cyc - last_edge >= DISC && disc_cyc - last_edge <= DISC + 4,
        "R8 disconnect timing", disc_cyc - last_edge, DISC + 3);
    send_bit(1'b1); send_bit(1'b0);
    compare("R9 silent after disconnect");

    summary();
  end
endmodule